// File: doc/BRIEF.md
# Three-Stage Pipelined 32-bit Integer Core

This block is a compact processor core for the 32-bit base integer instruction set. It executes register and immediate arithmetic, logic, shifts and compares, upper-immediate loads, PC-relative address generation, all six conditional branches, both jump-and-link forms, and word loads and stores. Instructions flow through three stages: fetch, a combined decode/register-read/execute/branch-resolve stage, and a writeback stage that also completes loads from the internal data memory.

The instruction memory is internal and is written through a preload port, normally while the core is held in reset. After reset is released the core fetches from address 0 and issues one instruction per cycle. A result still sitting in writeback is forwarded to a dependent instruction in execute, so back-to-back dependencies, including a load followed at once by its user, need no stall. A taken branch or jump discards the single instruction fetched behind it. An observation port reads any architectural register combinationally so that a program's outcome can be checked from outside.

Top module: `rv3_core`

## Requirements
- R1: While reset is asserted the PC is 0, no instruction is in flight, and every register reads 0 on the observation port; the first instruction executed after release is the word at byte address 0.
- R2: Register x0 always reads 0, both on the observation port and as a source operand; any instruction naming x0 as destination leaves it 0.
- R3: Register-register operations (opcode 0110011) compute ADD, SUB, SLL, SLT, SLTU, XOR, SRL, SRA, OR and AND, selected by funct3 and instruction bit 30, with shift amounts taken from rs2 bits 4:0.
- R4: Register-immediate operations (opcode 0010011) use the sign-extended 12-bit immediate (SRAI selected by bit 30); LUI places imm[31:12] in the upper bits with zeros below, and AUIPC adds that value to its own PC.
- R5: An instruction reading a register written by the instruction immediately before it receives the new value, not the stale register content.
- R6: BEQ, BNE, BLT, BGE, BLTU and BGEU (funct3 000, 001, 100, 101, 110, 111) redirect to PC plus the B-format offset when their condition holds, and the one instruction fetched after a taken branch makes no register or memory change.
- R7: JAL and JALR write their own PC plus 4 to rd; JAL targets PC plus the J-format offset and JALR targets (rs1 + I-immediate) with bit 0 cleared; the instruction fetched after either is discarded.
- R8: LW and SW (funct3 010) access the data word at byte address rs1 + offset, word index taken from address bits above bit 1; a load's result is usable by the very next instruction and a store is visible to every later load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_we | input | 1 | Instruction memory preload write enable |
| imem_waddr | input | IAW (6) | Preload word index |
| imem_wdata | input | 32 | Preload instruction word |
| obs_addr | input | 5 | Register number to observe |
| obs_data | output | 32 | Current content of the observed register |

## Verification
Random arithmetic streams over only eight registers make nearly every instruction depend on its predecessor, so a core without forwarding, or one forwarding a write to x0, ends with wrong register values. Branch programs pair equal, random and opposite-sign operands for every condition, catching signed and unsigned compares that are swapped and a fall-through instruction that escapes squashing by bumping its own counter register. A jump program checks link values, JALR bit-0 clearing on an odd target and use of a link value in the next instruction, while load/store sequences with immediate reuse expose a load result that arrives a cycle late or a store written to the wrong word.

// File: rtl/rv3_pkg.sv
package rv3_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RAW  = $clog2(NREG);

  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
    ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR, ALU_AND
  } alu_op_e;

  typedef struct packed {
    logic            rd_we;
    logic            load;
    logic            store;
    logic            branch;
    logic            jal;
    logic            jalr;
    logic            a_pc;
    logic            a_zero;
    logic            b_imm;
    alu_op_e         alu_op;
    logic [2:0]      f3;
    logic [RAW-1:0]  rd;
    logic [RAW-1:0]  rs1;
    logic [RAW-1:0]  rs2;
    logic [XLEN-1:0] imm;
  } ctrl_t;
endpackage

// File: rtl/rv3_decode.sv
module rv3_decode
  import rv3_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output ctrl_t           ctl
);
  function automatic alu_op_e arith(input logic [2:0] f3, input logic sub_alt,
                                    input logic sra_alt);
    case (f3)
      3'd0:    return sub_alt ? ALU_SUB : ALU_ADD;
      3'd1:    return ALU_SLL;
      3'd2:    return ALU_SLT;
      3'd3:    return ALU_SLTU;
      3'd4:    return ALU_XOR;
      3'd5:    return sra_alt ? ALU_SRA : ALU_SRL;
      3'd6:    return ALU_OR;
      default: return ALU_AND;
    endcase
  endfunction

  logic [XLEN-1:0] imm_i, imm_s, imm_b, imm_u, imm_j;

  always_comb begin
    imm_i = {{20{instr[31]}}, instr[31:20]};
    imm_s = {{20{instr[31]}}, instr[31:25], instr[11:7]};
    imm_b = {{19{instr[31]}}, instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
    imm_u = {instr[31:12], 12'b0};
    imm_j = {{11{instr[31]}}, instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};
  end

  always_comb begin
    ctl     = '0;
    ctl.f3  = instr[14:12];
    ctl.rd  = instr[11:7];
    ctl.rs1 = instr[19:15];
    ctl.rs2 = instr[24:20];
    case (instr[6:0])
      OPC_OP: begin
        ctl.rd_we  = 1'b1;
        ctl.alu_op = arith(instr[14:12], instr[30], instr[30]);
      end
      OPC_OPIMM: begin
        ctl.rd_we  = 1'b1;
        ctl.b_imm  = 1'b1;
        ctl.imm    = imm_i;
        ctl.alu_op = arith(instr[14:12], 1'b0, instr[30]);
      end
      OPC_LUI: begin
        ctl.rd_we  = 1'b1;
        ctl.a_zero = 1'b1;
        ctl.b_imm  = 1'b1;
        ctl.imm    = imm_u;
      end
      OPC_AUIPC: begin
        ctl.rd_we = 1'b1;
        ctl.a_pc  = 1'b1;
        ctl.b_imm = 1'b1;
        ctl.imm   = imm_u;
      end
      OPC_JAL: begin
        ctl.rd_we = 1'b1;
        ctl.jal   = 1'b1;
        ctl.imm   = imm_j;
      end
      OPC_JALR: begin
        ctl.rd_we = 1'b1;
        ctl.jalr  = 1'b1;
        ctl.imm   = imm_i;
      end
      OPC_BRANCH: begin
        ctl.branch = 1'b1;
        ctl.imm    = imm_b;
      end
      OPC_LOAD: begin
        ctl.rd_we = 1'b1;
        ctl.load  = 1'b1;
        ctl.b_imm = 1'b1;
        ctl.imm   = imm_i;
      end
      OPC_STORE: begin
        ctl.store = 1'b1;
        ctl.b_imm = 1'b1;
        ctl.imm   = imm_s;
      end
      default: ctl.rd_we = 1'b0;
    endcase
  end
endmodule

// File: rtl/rv3_alu.sv
module rv3_alu
  import rv3_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y
);
  logic [4:0] sh;

  always_comb begin
    sh = b[4:0];
    case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_SLL:  y = a << sh;
      ALU_SLT:  y = {31'b0, $signed(a) < $signed(b)};
      ALU_SLTU: y = {31'b0, a < b};
      ALU_XOR:  y = a ^ b;
      ALU_SRL:  y = a >> sh;
      ALU_SRA:  y = $unsigned($signed(a) >>> sh);
      ALU_OR:   y = a | b;
      default:  y = a & b;
    endcase
  end
endmodule

// File: rtl/rv3_regfile.sv
module rv3_regfile
  import rv3_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [RAW-1:0]  waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [RAW-1:0]  ra1,
  input  logic [RAW-1:0]  ra2,
  input  logic [RAW-1:0]  ra3,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2,
  output logic [XLEN-1:0] rd3
);
  logic [NREG-1:0][XLEN-1:0] regs;

  assign regs[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    logic            en;
    logic [XLEN-1:0] q;
    assign en = we && (waddr == RAW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata;
    end
    assign regs[g] = q;
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
  assign rd3 = regs[ra3];
endmodule

// File: rtl/rv3_core.sv
module rv3_core
  import rv3_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 32,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            imem_we,
  input  logic [IAW-1:0]  imem_waddr,
  input  logic [XLEN-1:0] imem_wdata,
  input  logic [RAW-1:0]  obs_addr,
  output logic [XLEN-1:0] obs_data
);
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  // Control state (reset) and payload state (no reset)
  logic [XLEN-1:0] pc, pc_d;
  logic            ex_valid, ex_valid_d;
  logic            wb_valid, wb_valid_d;
  logic [XLEN-1:0] ex_pc, ex_instr;
  logic            wb_we, wb_load;
  logic [RAW-1:0]  wb_rd;
  logic [XLEN-1:0] wb_result;
  logic [DAW-1:0]  wb_idx;

  ctrl_t           ctl;
  logic [XLEN-1:0] rf_a, rf_b, rs1v, rs2v, alu_a, alu_b, alu_y;
  logic [XLEN-1:0] target, ex_result, wb_data;
  logic            take, redirect, dmem_we, rf_we;
  logic [DAW-1:0]  dmem_idx;

  always_ff @(posedge clk) begin
    if (imem_we) imem[imem_waddr] <= imem_wdata;
  end

  rv3_decode u_dec (.instr(ex_instr), .ctl(ctl));

  assign rf_we = wb_valid & wb_we;

  rv3_regfile u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(wb_rd), .wdata(wb_data),
    .ra1(ctl.rs1), .ra2(ctl.rs2), .ra3(obs_addr),
    .rd1(rf_a), .rd2(rf_b), .rd3(obs_data)
  );

  // Execute: operand forwarding from writeback
  always_comb begin
    rs1v = (rf_we && wb_rd == ctl.rs1 && ctl.rs1 != '0) ? wb_data : rf_a;
    rs2v = (rf_we && wb_rd == ctl.rs2 && ctl.rs2 != '0) ? wb_data : rf_b;
    alu_a = ctl.a_zero ? '0 : (ctl.a_pc ? ex_pc : rs1v);
    alu_b = ctl.b_imm ? ctl.imm : rs2v;
  end

  rv3_alu u_alu (.a(alu_a), .b(alu_b), .op(ctl.alu_op), .y(alu_y));

  // Execute: branch resolution and redirect
  always_comb begin
    case (ctl.f3)
      3'b000:  take = (rs1v == rs2v);
      3'b001:  take = (rs1v != rs2v);
      3'b100:  take = ($signed(rs1v) <  $signed(rs2v));
      3'b101:  take = ($signed(rs1v) >= $signed(rs2v));
      3'b110:  take = (rs1v <  rs2v);
      3'b111:  take = (rs1v >= rs2v);
      default: take = 1'b0;
    endcase
    target    = ctl.jalr ? ((rs1v + ctl.imm) & ~32'd1) : (ex_pc + ctl.imm);
    redirect  = ex_valid & (ctl.jal | ctl.jalr | (ctl.branch & take));
    ex_result = (ctl.jal | ctl.jalr) ? (ex_pc + 32'd4) : alu_y;
    dmem_we   = ex_valid & ctl.store;
    dmem_idx  = alu_y[DAW+1:2];
  end

  always_ff @(posedge clk) begin
    if (dmem_we) dmem[dmem_idx] <= rs2v;
  end

  assign wb_data = wb_load ? dmem[wb_idx] : wb_result;

  // Next-state for control registers
  always_comb begin
    pc_d       = redirect ? target : (pc + 32'd4);
    ex_valid_d = ~redirect;
    wb_valid_d = ex_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc       <= '0;
      ex_valid <= 1'b0;
      wb_valid <= 1'b0;
    end else begin
      pc       <= pc_d;
      ex_valid <= ex_valid_d;
      wb_valid <= wb_valid_d;
    end
  end

  // Payload registers, loaded every cycle
  always_ff @(posedge clk) begin
    ex_pc     <= pc;
    ex_instr  <= imem[pc[IAW+1:2]];
    wb_we     <= ex_valid & ctl.rd_we;
    wb_load   <= ctl.load;
    wb_rd     <= ctl.rd;
    wb_result <= ex_result;
    wb_idx    <= dmem_idx;
  end
endmodule

// File: rtl/rv3_core_chk.sv
module rv3_core_chk
  import rv3_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [XLEN-1:0] pc,
  input logic            ex_valid,
  input logic            wb_valid,
  input logic            redirect,
  input logic            link,
  input logic [XLEN-1:0] ex_pc,
  input logic [XLEN-1:0] wb_result,
  input logic [RAW-1:0]  obs_addr,
  input logic [XLEN-1:0] obs_data
);
  // R1: first cycle out of reset starts at PC 0 with an empty pipeline
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (pc == '0 && !ex_valid && !wb_valid));

  // R2: x0 observed as zero
  p_x0_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (obs_addr == '0) |-> (obs_data == '0));

  // R6: instruction fetched behind a redirect does not reach execute
  p_squash_r6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !ex_valid);

  // R7: link value reaches writeback
  p_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
    link |=> (wb_valid && wb_result == $past(ex_pc) + 32'd4));

  // R7: fetch address stays even (JALR clears bit 0)
  p_pc_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pc[0] == 1'b0);
endmodule

bind rv3_core rv3_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pc(pc), .ex_valid(ex_valid), .wb_valid(wb_valid),
  .redirect(redirect), .link(ex_valid & (ctl.jal | ctl.jalr)), .ex_pc(ex_pc),
  .wb_result(wb_result), .obs_addr(obs_addr), .obs_data(obs_data)
);

// File: tb/rv3_core_tb.sv
`timescale 1ns/1ps
module rv3_core_tb;
  localparam int IW = 64;
  localparam logic [6:0] O_LUI = 7'b0110111, O_AUIPC = 7'b0010111, O_JAL = 7'b1101111,
                         O_JALR = 7'b1100111, O_BR = 7'b1100011, O_LD = 7'b0000011,
                         O_ST = 7'b0100011, O_OPI = 7'b0010011, O_OP = 7'b0110011;
  localparam logic [31:0] HALT = 32'h0000006F;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        imem_we;
  logic [5:0]  imem_waddr;
  logic [31:0] imem_wdata;
  logic [4:0]  obs_addr;
  logic [31:0] obs_data;

  int checks = 0;
  int fails  = 0;

  logic [31:0] prog [IW];
  logic [31:0] m_r  [32];
  logic [31:0] m_d  [32];

  always #2 clk = ~clk;

  rv3_core u_dut (
    .clk(clk), .rst_n(rst_n), .imem_we(imem_we), .imem_waddr(imem_waddr),
    .imem_wdata(imem_wdata), .obs_addr(obs_addr), .obs_data(obs_data)
  );

  function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2, rs1,
                                        input logic [2:0] f3, input logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, O_OP};
  endfunction
  function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                        input logic [2:0] f3, input logic [4:0] rd,
                                        input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] enc_s(input logic [11:0] imm, input logic [4:0] rs2, rs1);
    return {imm[11:5], rs2, rs1, 3'b010, imm[4:0], O_ST};
  endfunction
  function automatic logic [31:0] enc_b(input logic [12:0] imm, input logic [4:0] rs2, rs1,
                                        input logic [2:0] f3);
    return {imm[12], imm[10:5], rs2, rs1, f3, imm[4:1], imm[11], O_BR};
  endfunction
  function automatic logic [31:0] enc_u(input logic [19:0] imm, input logic [4:0] rd,
                                        input logic [6:0] op);
    return {imm, rd, op};
  endfunction
  function automatic logic [31:0] enc_j(input logic [20:0] imm, input logic [4:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, O_JAL};
  endfunction

  function automatic logic [31:0] ref_alu(input logic [2:0] f3, input logic [31:0] a, b,
                                          input logic alt_sra, input logic alt_sub);
    case (f3)
      3'd0: return alt_sub ? a - b : a + b;
      3'd1: return a << b[4:0];
      3'd2: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      3'd3: return (a < b) ? 32'd1 : 32'd0;
      3'd4: return a ^ b;
      3'd5: return alt_sra ? $unsigned($signed(a) >>> b[4:0]) : a >> b[4:0];
      3'd6: return a | b;
      default: return a & b;
    endcase
  endfunction

  // Reference instruction-level model of the requirements
  task automatic iss_run();
    logic [31:0] pc, ins, a, b, res, nxt, ii, is, ib, iu, ij;
    logic [4:0]  rd;
    logic [2:0]  f3;
    logic        wr, tk;
    for (int r = 0; r < 32; r++) m_r[r] = '0;
    pc = '0;
    for (int step = 0; step < 2000; step++) begin
      ins = prog[pc[7:2]];
      if (ins == HALT) break;
      rd = ins[11:7]; f3 = ins[14:12];
      a = m_r[ins[19:15]]; b = m_r[ins[24:20]];
      ii = {{20{ins[31]}}, ins[31:20]};
      is = {{20{ins[31]}}, ins[31:25], ins[11:7]};
      ib = {{19{ins[31]}}, ins[31], ins[7], ins[30:25], ins[11:8], 1'b0};
      iu = {ins[31:12], 12'b0};
      ij = {{11{ins[31]}}, ins[31], ins[19:12], ins[20], ins[30:21], 1'b0};
      nxt = pc + 4; wr = 1'b1; res = '0;
      case (ins[6:0])
        O_LUI:   res = iu;
        O_AUIPC: res = pc + iu;
        O_JAL:   begin res = pc + 4; nxt = pc + ij; end
        O_JALR:  begin res = pc + 4; nxt = (a + ii) & ~32'd1; end
        O_BR: begin
          wr = 1'b0;
          case (f3)
            3'b000: tk = (a == b);
            3'b001: tk = (a != b);
            3'b100: tk = ($signed(a) < $signed(b));
            3'b101: tk = ($signed(a) >= $signed(b));
            3'b110: tk = (a < b);
            3'b111: tk = (a >= b);
            default: tk = 1'b0;
          endcase
          if (tk) nxt = pc + ib;
        end
        O_LD:  res = m_d[(a + ii) >> 2 & 32'd31];
        O_ST:  begin wr = 1'b0; m_d[(a + is) >> 2 & 32'd31] = b; end
        O_OPI: res = ref_alu(f3, a, ii, (f3 == 3'd5) && ins[30], 1'b0);
        O_OP:  res = ref_alu(f3, a, b, (f3 == 3'd5) && ins[30], (f3 == 3'd0) && ins[30]);
        default: wr = 1'b0;
      endcase
      if (wr && rd != 5'd0) m_r[rd] = res;
      pc = nxt;
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, exp, input int idx);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s x%0d actual=%08h expected=%08h", tag, idx, act, exp);
    end
  endtask

  task automatic run_prog(input string tag, input int len);
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < IW; i++) begin
      @(negedge clk);
      imem_we = 1'b1; imem_waddr = 6'(i); imem_wdata = prog[i];
    end
    @(negedge clk);
    imem_we = 1'b0;
    for (int r = 0; r < 32; r++) begin
      obs_addr = 5'(r); #0.5;
      check("R1 reset", obs_data, 32'd0, r);
    end
    rst_n = 1'b1;
    repeat (3 * len + 30) @(negedge clk);
    iss_run();
    for (int r = 0; r < 32; r++) begin
      obs_addr = 5'(r); #0.5;
      check(tag, obs_data, m_r[r], r);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < IW; i++) prog[i] = HALT;
  endtask

  task automatic load_consts(inout int idx, input int lo, hi);
    for (int r = lo; r <= hi; r++) begin
      prog[idx] = enc_u(20'($urandom), 5'(r), O_LUI); idx++;
      prog[idx] = enc_i(12'($urandom), 5'(r), 3'd0, 5'(r), O_OPI); idx++;
    end
  endtask

  task automatic gen_alu();
    int idx = 0;
    logic [2:0] f3; logic [4:0] rd, s1, s2; logic [11:0] imm; logic [6:0] f7;
    clear_prog();
    load_consts(idx, 1, 8);
    for (int k = 0; k < 40; k++) begin
      f3 = 3'($urandom_range(0, 7));
      rd = 5'($urandom_range(1, 8)); s1 = 5'($urandom_range(1, 8)); s2 = 5'($urandom_range(1, 8));
      if ($urandom_range(0, 1) == 1) begin
        f7 = ((f3 == 3'd0 || f3 == 3'd5) && $urandom_range(0, 1) == 1) ? 7'h20 : 7'h00;
        prog[idx] = enc_r(f7, s2, s1, f3, rd);
      end else begin
        imm = 12'($urandom);
        if (f3 == 3'd1) imm = {7'h00, imm[4:0]};
        if (f3 == 3'd5) imm = {($urandom_range(0, 1) == 1) ? 7'h20 : 7'h00, imm[4:0]};
        prog[idx] = enc_i(imm, s1, f3, rd, O_OPI);
      end
      idx++;
    end
    prog[idx] = enc_u(20'($urandom), 5'd9, O_AUIPC);
  endtask

  task automatic gen_branch(input int pat);
    int idx = 0;
    logic [2:0] fl [6] = '{3'b000, 3'b001, 3'b100, 3'b101, 3'b110, 3'b111};
    logic [11:0] va, vb;
    clear_prog();
    for (int k = 0; k < 6; k++) begin
      va = 12'($urandom); vb = 12'($urandom);
      if (pat == 0) vb = va;
      if (pat == 2) begin va = 12'(-$urandom_range(1, 500)); vb = 12'($urandom_range(1, 500)); end
      if (pat == 2 && k[0]) begin vb = va; va = 12'($urandom_range(1, 500)); end
      prog[idx] = enc_i(va, 5'd0, 3'd0, 5'd1, O_OPI); idx++;
      prog[idx] = enc_i(vb, 5'd0, 3'd0, 5'd2, O_OPI); idx++;
      prog[idx] = enc_b(13'd8, 5'd2, 5'd1, fl[k]); idx++;
      prog[idx] = enc_i(12'd1, 5'(10 + k), 3'd0, 5'(10 + k), O_OPI); idx++;
      prog[idx] = enc_i(12'd1, 5'd20, 3'd0, 5'd20, O_OPI); idx++;
    end
  endtask

  task automatic gen_ls();
    int idx = 0;
    logic [4:0] ra, rb; logic [11:0] off;
    clear_prog();
    prog[idx] = enc_i(12'(4 * $urandom_range(0, 16)), 5'd0, 3'd0, 5'd1, O_OPI); idx++;
    load_consts(idx, 2, 5);
    for (int o = 0; o < 4; o++) begin
      prog[idx] = enc_s(12'(4 * o), 5'(2 + o), 5'd1); idx++;
    end
    for (int k = 0; k < 36; k++) begin
      ra = 5'($urandom_range(2, 7)); rb = 5'($urandom_range(2, 7));
      off = 12'(4 * $urandom_range(0, 3));
      case ($urandom_range(0, 2))
        0: prog[idx] = enc_s(off, ra, 5'd1);
        1: prog[idx] = enc_i(off, 5'd1, 3'b010, ra, O_LD);
        default: prog[idx] = enc_r(7'h00, rb, ra, 3'd0, ra);
      endcase
      idx++;
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int unused_seed;
    rst_n = 1'b0; imem_we = 1'b0; imem_waddr = '0; imem_wdata = '0; obs_addr = '0;
    unused_seed = $urandom(32'd20511);
    for (int i = 0; i < 32; i++) m_d[i] = '0;

    // R2: writes to x0 ignored, x0 never forwarded
    clear_prog();
    prog[0] = enc_i(12'd5, 5'd0, 3'd0, 5'd0, O_OPI);
    prog[1] = enc_r(7'h00, 5'd0, 5'd0, 3'd0, 5'd1);
    prog[2] = enc_u(20'h12345, 5'd0, O_LUI);
    prog[3] = enc_i(12'd0, 5'd0, 3'd0, 5'd2, O_OPI);
    prog[4] = enc_i(12'hFFF, 5'd0, 3'd0, 5'd3, O_OPI);
    prog[5] = enc_r(7'h00, 5'd3, 5'd3, 3'd0, 5'd0);
    prog[6] = enc_r(7'h00, 5'd3, 5'd0, 3'd0, 5'd4);
    run_prog("R2", 8);

    // R3/R4/R5: dependent random arithmetic streams
    for (int n = 0; n < 4; n++) begin
      gen_alu();
      run_prog("R3/R4/R5", 60);
    end

    // R6: every condition with equal, random and mixed-sign operands
    for (int p = 0; p < 3; p++) begin
      gen_branch(p);
      run_prog("R6", 32);
    end

    // R7: jumps, odd JALR target, immediate use of link values
    clear_prog();
    prog[0]  = enc_j(21'd12, 5'd5);
    prog[1]  = enc_i(12'd1, 5'd0, 3'd0, 5'd6, O_OPI);
    prog[2]  = enc_i(12'd2, 5'd0, 3'd0, 5'd6, O_OPI);
    prog[3]  = enc_i(12'd3, 5'd0, 3'd0, 5'd7, O_OPI);
    prog[4]  = enc_i(12'd33, 5'd0, 3'd0, 5'd8, O_OPI);
    prog[5]  = enc_i(12'd0, 5'd8, 3'd0, 5'd9, O_JALR);
    prog[6]  = enc_i(12'd4, 5'd0, 3'd0, 5'd6, O_OPI);
    prog[7]  = enc_i(12'd5, 5'd0, 3'd0, 5'd6, O_OPI);
    prog[8]  = enc_i(12'd1, 5'd9, 3'd0, 5'd10, O_OPI);
    prog[9]  = enc_i(12'd19, 5'd10, 3'd0, 5'd11, O_JALR);
    prog[10] = enc_i(12'd7, 5'd0, 3'd0, 5'd12, O_OPI);
    prog[11] = enc_j(21'd8, 5'd13);
    prog[12] = enc_i(12'd8, 5'd0, 3'd0, 5'd12, O_OPI);
    prog[13] = enc_i(12'd0, 5'd13, 3'd0, 5'd14, O_OPI);
    run_prog("R7", 16);

    // R8: word stores and loads with back-to-back use
    for (int n = 0; n < 2; n++) begin
      gen_ls();
      run_prog("R8", 50);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule